// File: doc/BRIEF.md
# Oscillator Lock Alarm and Shutdown Controller

This block watches a bank of free-running oscillators whose sampled bits are mixed into an entropy stream. When an oscillator locks to the sampling clock, its samples fall into a repeating pattern. The block detects such repeats on each oscillator's recent samples and counts them. Once the count goes past a programmable limit, it raises an alarm and switches that oscillator off, so it stops feeding the entropy stream.

Software sees a per-oscillator sticky alarm status and a maskable interrupt. It then has two choices. It can set the oscillator's detune bit and turn the oscillator back on. Or it can leave the oscillator off. A detune bit can only be changed while its oscillator is off. The entropy output is the XOR of the sampled bits of the oscillators that are enabled at that moment.

Top module: `osc_lock_guard`

## Requirements
- R1: After reset, all enable, detune, status, alarm-event and interrupt outputs are 0, the entropy output is 0, and the threshold is 255.
- R2: A repeat detection happens on an accepted sample (sample_vld_i high) of an enabled oscillator. It requires at least 16 samples since that oscillator was last enabled, and the newest 8 samples must equal the 8 samples taken just before them.
- R3: Each oscillator has an 8-bit saturating detection counter. The alarm fires on the detection that finds the counter already at or above the threshold, which is detection number threshold+1. alarm_evt_o[i] is then high for one cycle.
- R4: An alarm clears en_o[i] in the same cycle that alarm_evt_o[i] rises, one clock after the detection. The alarm takes priority over a software write to the enable register in that cycle.
- R5: A write to a detune bit takes effect only if that oscillator's en_o bit is 0. While the oscillator is enabled, the detune bit keeps its old value.
- R6: An oscillator whose enable bit is 0 never raises an alarm event or sets its status bit.
- R7: While an oscillator is disabled, its detection counter and sample history are held at zero. When it is re-enabled, the next alarm needs the full 16 + threshold samples of a repeating pattern.
- R8: alarm_stat_o[i] is set by an alarm and cleared by writing 1 to stat_clr_i[i]. If both happen in the same cycle, the set wins. irq_o is registered and equals the OR of (alarm_stat_o & ~irq_mask_i) from the previous cycle.
- R9: On each accepted sample, entropy_o becomes the XOR of the osc_bits_i bits whose en_o bit is 1, one clock later. entropy_vld_o marks that cycle.
- R10: Writing thr_wr_i loads thr_o with thr_wdata_i on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_vld_i | input | 1 | Strobe: osc_bits_i holds a new sample |
| osc_bits_i | input | N_OSC | One sampled bit per oscillator |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | N_OSC | Enable write data |
| det_wr_i | input | 1 | Write strobe for the detune register |
| det_wdata_i | input | N_OSC | Detune write data |
| thr_wr_i | input | 1 | Write strobe for the alarm threshold |
| thr_wdata_i | input | CNT_W | Threshold write data |
| stat_clr_i | input | N_OSC | Write-one-to-clear for the status bits |
| irq_mask_i | input | N_OSC | Interrupt mask, 1 = masked |
| en_o | output | N_OSC | Oscillator enable bits |
| detune_o | output | N_OSC | Oscillator detune bits |
| thr_o | output | CNT_W | Current alarm threshold |
| alarm_evt_o | output | N_OSC | One-cycle alarm event pulse per oscillator |
| alarm_stat_o | output | N_OSC | Sticky alarm status |
| irq_o | output | 1 | Interrupt |
| entropy_o | output | 1 | Mixed entropy bit |
| entropy_vld_o | output | 1 | entropy_o carries a new bit |

## Verification
The assertions check on every cycle the properties that hold between outputs. An alarm pulse always comes with a cleared enable and a set status bit. A disabled oscillator never produces an alarm pulse on the next cycle. A detune bit never moves while its oscillator was enabled. The entropy valid flag follows the sample strobe by one cycle.

Only the directed scenarios can show the counting behaviour. This covers the exact sample on which the alarm fires for the default threshold and for a lowered one. It also covers the reset of the counter after re-enabling, the interaction between mask, status and interrupt, and the XOR of enabled bits.

// File: rtl/osc_lock_pkg.sv
package osc_lock_pkg;
  localparam int unsigned CNT_W_DEF = 8;
  localparam int unsigned PAT_W_DEF = 8;
  localparam logic [CNT_W_DEF-1:0] THR_RST = '1;
endpackage

// File: rtl/osc_pattern_det.sv
module osc_pattern_det #(
  parameter int unsigned PAT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic smp_vld_i,
  input  logic smp_i,
  output logic rep_o
);
  localparam int unsigned HIST_W = 2 * PAT_W;
  localparam int unsigned FILL_W = $clog2(HIST_W + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(HIST_W);
  localparam logic [FILL_W-1:0] FILL_ARM = FILL_W'(HIST_W - 1);

  logic [HIST_W-1:0] hist_q, hist_d;
  logic [FILL_W-1:0] fill_q;
  logic              rep_q;

  assign hist_d = {hist_q[HIST_W-2:0], smp_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
      rep_q  <= 1'b0;
    end else if (!en_i) begin
      hist_q <= '0;
      fill_q <= '0;
      rep_q  <= 1'b0;
    end else if (smp_vld_i) begin
      hist_q <= hist_d;
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
      // match only once a full double window has been collected
      rep_q  <= (fill_q >= FILL_ARM) &&
                (hist_d[PAT_W-1:0] == hist_d[HIST_W-1:PAT_W]);
    end else begin
      rep_q  <= 1'b0;
    end
  end

  assign rep_o = rep_q;
endmodule

// File: rtl/osc_alarm_cnt.sv
module osc_alarm_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rep_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             alarm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  // alarm on the detection that pushes the count past thr
  assign alarm_o = en_i & rep_i & (cnt_q >= thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!en_i)                    cnt_q <= '0;
    else if (rep_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/osc_entropy_mix.sv
module osc_entropy_mix #(
  parameter int unsigned N_OSC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [N_OSC-1:0] smp_i,
  input  logic [N_OSC-1:0] en_i,
  output logic             bit_o,
  output logic             vld_o
);
  logic bit_q, vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= smp_vld_i;
      if (smp_vld_i) bit_q <= ^(smp_i & en_i);
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/osc_lock_guard.sv
module osc_lock_guard
  import osc_lock_pkg::*;
#(
  parameter int unsigned N_OSC = 8,
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned PAT_W = PAT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_vld_i,
  input  logic [N_OSC-1:0] osc_bits_i,
  input  logic             en_wr_i,
  input  logic [N_OSC-1:0] en_wdata_i,
  input  logic             det_wr_i,
  input  logic [N_OSC-1:0] det_wdata_i,
  input  logic             thr_wr_i,
  input  logic [CNT_W-1:0] thr_wdata_i,
  input  logic [N_OSC-1:0] stat_clr_i,
  input  logic [N_OSC-1:0] irq_mask_i,
  output logic [N_OSC-1:0] en_o,
  output logic [N_OSC-1:0] detune_o,
  output logic [CNT_W-1:0] thr_o,
  output logic [N_OSC-1:0] alarm_evt_o,
  output logic [N_OSC-1:0] alarm_stat_o,
  output logic             irq_o,
  output logic             entropy_o,
  output logic             entropy_vld_o
);
  localparam logic [CNT_W-1:0] THR_INIT = CNT_W'(THR_RST);

  logic [N_OSC-1:0] en_q, det_q, stat_q, evt_q;
  logic [N_OSC-1:0] rep, alarm;
  logic [CNT_W-1:0] thr_q;
  logic             irq_q;

  for (genvar g = 0; g < N_OSC; g++) begin : g_osc
    osc_pattern_det #(.PAT_W(PAT_W)) u_det (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_q[g]),
      .smp_vld_i (sample_vld_i),
      .smp_i     (osc_bits_i[g]),
      .rep_o     (rep[g])
    );
    osc_alarm_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_q[g]),
      .rep_i   (rep[g]),
      .thr_i   (thr_q),
      .alarm_o (alarm[g])
    );
  end

  osc_entropy_mix #(.N_OSC(N_OSC)) u_mix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_vld_i (sample_vld_i),
    .smp_i     (osc_bits_i),
    .en_i      (en_q),
    .bit_o     (entropy_o),
    .vld_o     (entropy_vld_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      det_q  <= '0;
      stat_q <= '0;
      evt_q  <= '0;
      thr_q  <= THR_INIT;
      irq_q  <= 1'b0;
    end else begin
      // alarm shutdown overrides a concurrent software write
      en_q   <= (en_wr_i ? en_wdata_i : en_q) & ~alarm;
      if (det_wr_i) det_q <= (det_q & en_q) | (det_wdata_i & ~en_q);
      if (thr_wr_i) thr_q <= thr_wdata_i;
      stat_q <= (stat_q & ~stat_clr_i) | alarm;
      evt_q  <= alarm;
      irq_q  <= |(stat_q & ~irq_mask_i);
    end
  end

  assign en_o         = en_q;
  assign detune_o     = det_q;
  assign thr_o        = thr_q;
  assign alarm_evt_o  = evt_q;
  assign alarm_stat_o = stat_q;
  assign irq_o        = irq_q;
endmodule

// File: rtl/osc_lock_guard_chk.sv
module osc_lock_guard_chk #(
  parameter int unsigned N_OSC = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_vld_i,
  input logic [N_OSC-1:0] en_o,
  input logic [N_OSC-1:0] detune_o,
  input logic [N_OSC-1:0] alarm_evt_o,
  input logic [N_OSC-1:0] alarm_stat_o,
  input logic             entropy_vld_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  for (genvar g = 0; g < N_OSC; g++) begin : g_chk
    assert_evt_clears_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alarm_evt_o[g] |-> !en_o[g]);
    assert_evt_sets_stat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alarm_evt_o[g] |-> alarm_stat_o[g]);
    assert_off_no_alarm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_o[g] |=> !alarm_evt_o[g]);
    assert_detune_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_o[g] |=> $stable(detune_o[g]));
  end

  assert_vld_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (entropy_vld_o == $past(sample_vld_i)));
endmodule

bind osc_lock_guard osc_lock_guard_chk #(.N_OSC(N_OSC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sample_vld_i  (sample_vld_i),
  .en_o          (en_o),
  .detune_o      (detune_o),
  .alarm_evt_o   (alarm_evt_o),
  .alarm_stat_o  (alarm_stat_o),
  .entropy_vld_o (entropy_vld_o)
);

// File: tb/osc_lock_guard_tb_top.sv
module osc_lock_guard_tb_top;
  localparam int N = 8;
  localparam logic [7:0] PAT = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic       smp_vld = 0, en_wr = 0, det_wr = 0, thr_wr = 0;
  logic [N-1:0] bits = '0, en_wd = '0, det_wd = '0, clr = '0, mask = '0;
  logic [7:0] thr_wd = '0;
  logic [N-1:0] en, det, evt, stat;
  logic [7:0] thr;
  logic irq, ent, ent_vld;

  int checks = 0, fails = 0, ph = 0;
  int evt_cnt [N];

  always #2.5 clk = ~clk;

  osc_lock_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_vld_i(smp_vld), .osc_bits_i(bits),
    .en_wr_i(en_wr), .en_wdata_i(en_wd), .det_wr_i(det_wr), .det_wdata_i(det_wd),
    .thr_wr_i(thr_wr), .thr_wdata_i(thr_wd), .stat_clr_i(clr), .irq_mask_i(mask),
    .en_o(en), .detune_o(det), .thr_o(thr), .alarm_evt_o(evt),
    .alarm_stat_o(stat), .irq_o(irq), .entropy_o(ent), .entropy_vld_o(ent_vld)
  );

  always @(negedge clk)
    for (int i = 0; i < N; i++) if (rst_n && evt[i]) evt_cnt[i]++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sample(logic [N-1:0] b);
    @(negedge clk); smp_vld = 1; bits = b;
    @(negedge clk); smp_vld = 0;
    idle(2);
  endtask

  task automatic run_pat(int osc, int n);
    for (int i = 0; i < n; i++) begin
      logic [N-1:0] b;
      b = '0;
      b[osc] = PAT[ph % 8];
      ph++;
      sample(b);
    end
  endtask

  task automatic wr_en(logic [N-1:0] v);
    @(negedge clk); en_wr = 1; en_wd = v;
    @(negedge clk); en_wr = 0;
  endtask

  task automatic wr_det(logic [N-1:0] v);
    @(negedge clk); det_wr = 1; det_wd = v;
    @(negedge clk); det_wr = 0;
  endtask

  task automatic t_reset;
    chk("R1 en", en, 0);          chk("R1 detune", det, 0);
    chk("R1 thr", thr, 8'hFF);    chk("R1 stat", stat, 0);
    chk("R1 evt", evt, 0);        chk("R1 irq", irq, 0);
    chk("R1 entropy", ent, 0);
  endtask

  task automatic t_entropy;
    wr_en(8'h05);
    @(negedge clk); smp_vld = 1; bits = 8'h07;
    @(negedge clk); smp_vld = 0;
    chk("R9 vld", ent_vld, 1);    chk("R9 xor 07", ent, 0);
    sample(8'h03); chk("R9 xor 03 masked bit1", ent, 1);
    wr_en(8'h00);
    sample(8'hFF); chk("R9 all off", ent, 0);
  endtask

  task automatic t_detune;
    wr_en(8'h01);
    wr_det(8'hFF); idle(1); chk("R5 write while enabled", det, 8'hFE);
    wr_en(8'h00);
    wr_det(8'h00); idle(1); chk("R5 write while off", det, 8'h00);
  endtask

  task automatic t_default_thr;
    ph = 0;
    wr_en(8'h02);
    run_pat(1, 270); chk("R3 default thr no alarm yet", en[1], 1);
    run_pat(1, 1);
    chk("R4 default thr en cleared", en[1], 0);
    chk("R3 evt count", evt_cnt[1], 1);
    chk("R8 stat set", stat[1], 1);
    @(negedge clk); clr = 8'h02; @(negedge clk); clr = 0;
    chk("R8 stat cleared", stat[1], 0);
  endtask

  task automatic t_low_thr;
    @(negedge clk); thr_wr = 1; thr_wd = 8'd3; @(negedge clk); thr_wr = 0;
    chk("R10 thr load", thr, 3);
    ph = 0;
    wr_en(8'h01);
    run_pat(0, 18); chk("R3 thr3 before", en[0], 1);
    run_pat(0, 1);  chk("R4 thr3 cleared", en[0], 0);
    chk("R3 thr3 evt", evt_cnt[0], 1);
    idle(2); chk("R8 irq unmasked", irq, 1);
    @(negedge clk); mask = 8'h01; idle(2); chk("R8 irq masked", irq, 0);
    @(negedge clk); mask = 8'h00; clr = 8'h01; @(negedge clk); clr = 0;
    idle(2);
    chk("R8 stat w1c", stat[0], 0); chk("R8 irq low", irq, 0);
  endtask

  task automatic t_disabled;
    run_pat(0, 40);
    chk("R6 no new evt", evt_cnt[0], 1);
    chk("R6 stat stays 0", stat[0], 0);
  endtask

  task automatic t_reenable;
    wr_det(8'h01); idle(1); chk("R5 detune after alarm", det[0], 1);
    ph = 3;
    wr_en(8'h01);
    run_pat(0, 18); chk("R7 counter restarted", en[0], 1);
    run_pat(0, 1);  chk("R7 alarm again", en[0], 0);
    chk("R2 second evt", evt_cnt[0], 2);
  endtask

  initial begin
    for (int i = 0; i < N; i++) evt_cnt[i] = 0;
    idle(3);
    t_reset;
    rst_n = 1;
    idle(2);
    t_entropy;
    t_detune;
    t_default_thr;
    t_low_thr;
    t_disabled;
    t_reenable;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule